// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block gives a host a single 32-bit control word through which it reaches a bank of 16-bit PHY configuration registers. The host writes one command word holding a direction bit, an 8-bit register address and, for a write, 16 bits of data. The bridge then performs the access on an internal parallel register port and raises a busy flag in the same word until the access is over. For a read, the fetched value appears in the upper half of that word once busy drops, so the host's routine is: write the command, poll busy, then take bits 31:16.

The PHY side is modelled inside the block as an array of 16-bit registers with a fixed, parameterised access latency. Each access completes in a bounded number of clock cycles, so a host that polls at a coarse interval and gives up after a long timeout always sees completion well inside its window.

Top module: `phy_cmd_bridge`

## Requirements
- R1: After reset the control word reads 32'h0000_0000: not busy, direction 0, address 0, data 0.
- R2: A host write of the control word while idle is accepted; in the next cycle bit 7 (busy) reads 1, bit 0 holds the written direction (1 = write, 0 = read), bits 15:8 the address, bits 31:16 the written data, and bits 6:1 read 0 whatever the host wrote there.
- R3: Busy reads 1 for exactly LATENCY+1 cycles after the accepting clock edge and then falls once, to 0.
- R4: A write command stores bits 31:16 into the PHY register named by bits 15:8; a later read of that address returns it.
- R5: When a read command completes, bits 31:16 hold the addressed PHY register value, while bits 15:8 and bit 0 keep the command's address and direction.
- R6: When a write command completes, bits 31:16 keep the written data until the next command is accepted.
- R7: A host write of the control word while busy is ignored: the address, direction and completing result are those of the running command, and no PHY register is touched by it.
- R8: After reset, PHY register k (k = 0x00 to 0x30) holds 16'hA500 + k.
- R9: Addresses 0x31 to 0xFF lie outside the register bank: a write to them changes no register and a read of them returns 16'h0000.
- R10: A host read of the control word (valid with the write flag low) never changes the word or the PHY registers; hostReady is held at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostValid | input | 1 | Host access strobe for the control word |
| hostWrite | input | 1 | 1 = host writes the control word, 0 = host reads it |
| hostWdata | input | 32 | Command word written by the host |
| hostReady | output | 1 | Access accepted (always 1) |
| hostRdata | output | 32 | Current control word: data[31:16], address[15:8], busy[7], zero[6:1], direction[0] |

## Verification
A wrong controller state shows at the ports as a busy flag that either stays high beyond LATENCY+1 cycles or drops early, visible on the first poll after the expected edge. A corrupted command register shows up in the address or direction field in the cycle right after acceptance, and a wrong latch or PHY write path shows up as a wrong upper half at the busy-falling edge or on the next read of that address. Commands injected while busy are checked through both the completing word and a later read of the address they named.

// File: rtl/phyb_pkg.sv
package phyb_pkg;
  localparam int WORD_W = 32;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;
  localparam int DIR_BIT = 0;
  localparam int BUSY_BIT = 7;
  localparam int ADDR_LSB = 8;
  localparam int DATA_LSB = 16;

  typedef struct packed {
    logic loadCmd;  // accept a new command word
    logic finish;   // PHY access completes this cycle
    logic busy;     // transfer in progress
  } strobe_t;
endpackage

// File: rtl/phyb_ctrl.sv
module phyb_ctrl
  import phyb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostValid,
  input  logic    hostWrite,
  input  logic    phyAck,
  output logic    phyReq,
  output strobe_t strb
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;
  state_t state;

  logic accept;
  assign accept = hostValid && hostWrite && (state == S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (accept) state <= S_ISSUE;
        S_ISSUE: state <= S_WAIT;
        S_WAIT:  if (phyAck) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.loadCmd = accept;
    strb.finish  = (state == S_WAIT) && phyAck;
    strb.busy    = (state != S_IDLE);
    phyReq       = (state == S_ISSUE);
  end
endmodule

// File: rtl/phyb_dpath.sv
module phyb_dpath
  import phyb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [WORD_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] phyRdata,
  output logic [ADDR_W-1:0] phyAddr,
  output logic [DATA_W-1:0] phyWdata,
  output logic              phyWe,
  output logic [WORD_W-1:0] cmdWord
);
  logic              dirQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= 1'b0;
      addrQ <= '0;
      dataQ <= '0;
    end else if (strb.loadCmd) begin
      dirQ  <= hostWdata[DIR_BIT];
      addrQ <= hostWdata[ADDR_LSB +: ADDR_W];
      dataQ <= hostWdata[DATA_LSB +: DATA_W];
    end else if (strb.finish && !dirQ) begin
      dataQ <= phyRdata;
    end
  end

  assign phyAddr  = addrQ;
  assign phyWdata = dataQ;
  assign phyWe    = dirQ;

  always_comb begin
    cmdWord = '0;
    cmdWord[DIR_BIT]                = dirQ;
    cmdWord[BUSY_BIT]               = strb.busy;
    cmdWord[ADDR_LSB +: ADDR_W]     = addrQ;
    cmdWord[DATA_LSB +: DATA_W]     = dataQ;
  end
endmodule

// File: rtl/phyb_regbank.sv
module phyb_regbank
  import phyb_pkg::*;
#(
  parameter int REG_COUNT = 49,
  parameter int LATENCY   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [DATA_W-1:0] regs [REG_COUNT];
  logic [CNT_W-1:0]  cnt;
  logic              weQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              inRange;
  logic [IDX_W-1:0]  idx;

  assign inRange = (int'(addrQ) < REG_COUNT);
  assign idx     = addrQ[IDX_W-1:0];
  assign ack     = (cnt == CNT_W'(1));
  assign rdata   = inRange ? regs[idx] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      weQ    <= 1'b0;
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (req) begin
      cnt    <= CNT_W'(LATENCY);
      weQ    <= we;
      addrQ  <= addr;
      wdataQ <= wdata;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  for (genvar k = 0; k < REG_COUNT; k++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regs[k] <= DATA_W'(16'hA500 + k);
      end else if (ack && weQ && inRange && (int'(idx) == k)) begin
        regs[k] <= wdataQ;
      end
    end
  end
endmodule

// File: rtl/phy_cmd_bridge.sv
module phy_cmd_bridge
  import phyb_pkg::*;
#(
  parameter int REG_COUNT = 49,
  parameter int LATENCY   = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostValid,
  input  logic        hostWrite,
  input  logic [31:0] hostWdata,
  output logic        hostReady,
  output logic [31:0] hostRdata
);
  strobe_t           strb;
  logic              phyReq;
  logic              phyAck;
  logic              phyWe;
  logic [ADDR_W-1:0] phyAddr;
  logic [DATA_W-1:0] phyWdata;
  logic [DATA_W-1:0] phyRdata;

  assign hostReady = 1'b1;

  phyb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .phyAck(phyAck), .phyReq(phyReq), .strb(strb)
  );

  phyb_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWdata(hostWdata),
    .phyRdata(phyRdata), .phyAddr(phyAddr), .phyWdata(phyWdata),
    .phyWe(phyWe), .cmdWord(hostRdata)
  );

  phyb_regbank #(.REG_COUNT(REG_COUNT), .LATENCY(LATENCY)) u_bank (
    .clk(clk), .rstN(rstN), .req(phyReq), .we(phyWe), .addr(phyAddr),
    .wdata(phyWdata), .ack(phyAck), .rdata(phyRdata)
  );
endmodule

// File: rtl/phyb_checker.sv
module phyb_checker #(
  parameter int LATENCY = 6
) (
  input logic        clk,
  input logic        rstN,
  input logic        hostValid,
  input logic        hostWrite,
  input logic [31:0] hostRdata
);
  localparam int RUN_W = $clog2(LATENCY + 3);
  logic [RUN_W-1:0] busyRun;
  logic busy;
  assign busy = hostRdata[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (busy) busyRun <= busyRun + RUN_W'(1);
    else busyRun <= '0;
  end

  // R2: idle command write raises busy next cycle
  p_busy_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    hostValid && hostWrite && !busy |=> busy);

  // R2: unused bits always read zero
  p_zero_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    hostRdata[6:1] == 6'b0);

  // R3: busy never outlives its window
  p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun <= RUN_W'(LATENCY)));

  // R3: busy falls only after the full window
  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == RUN_W'(LATENCY + 1)));

  // R6: write result keeps its data field
  p_write_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) && hostRdata[0] |-> $stable(hostRdata[31:16]));

  // R7: command while busy leaves address and direction alone
  p_ignore_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy && hostValid && hostWrite |=> $stable(hostRdata[15:8]) && $stable(hostRdata[0]));

  // R10: host read while idle changes nothing
  p_read_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy && hostValid && !hostWrite |=> $stable(hostRdata));
endmodule

bind phy_cmd_bridge phyb_checker #(.LATENCY(LATENCY)) u_chk (
  .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
  .hostRdata(hostRdata)
);

// File: tb/phy_cmd_bridge_test.sv
module phy_cmd_bridge_test;
  localparam int REGS = 49;
  localparam int LAT  = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0;
  logic        hostWrite = 1'b0;
  logic [31:0] hostWdata = '0;
  logic        hostReady;
  logic [31:0] hostRdata;

  int nChecks = 0;
  int nFails  = 0;
  logic [15:0] model [REGS];
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        prevBusy = 1'b0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  phy_cmd_bridge #(.REG_COUNT(REGS), .LATENCY(LAT)) uut (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostWdata(hostWdata), .hostReady(hostReady), .hostRdata(hostRdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] modelRead(input logic [7:0] a);
    if (int'(a) < REGS) return model[a];
    return 16'h0000;
  endfunction

  // monitor: compare the word at every busy-falling point
  always @(negedge clk) begin
    if (prevBusy && !hostRdata[7]) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3 unexpected completion", hostRdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(hostRdata == e, t, hostRdata, e);
      end
    end
    prevBusy = hostRdata[7];
  end

  // intrude: 0 none, 1 command write while busy, 2 host read while busy
  task automatic doCmd(input logic w, input logic [7:0] a, input logic [15:0] d,
                       input int intrude, input string tag);
    logic [31:0] expFinal;
    int busyCnt;
    expFinal = w ? {d, a, 8'h01} : {modelRead(a), a, 8'h00};
    expQ.push_back(expFinal);
    tagQ.push_back(tag);
    @(negedge clk);
    hostValid = 1'b1; hostWrite = 1'b1;
    hostWdata = {d, a, 7'h55, w};
    @(negedge clk);
    hostValid = 1'b0;
    check(hostRdata == {d, a, 7'b1000000, w}, "R2 accepted word", hostRdata,
          {d, a, 7'b1000000, w});
    busyCnt = 1;
    for (int i = 0; i < LAT + 10; i++) begin
      if (i == 2 && intrude == 1) begin
        hostValid = 1'b1; hostWrite = 1'b1; hostWdata = 32'h5555_2101;
      end else if (i == 2 && intrude == 2) begin
        hostValid = 1'b1; hostWrite = 1'b0; hostWdata = 32'hFFFF_FFFF;
      end
      @(negedge clk);
      hostValid = 1'b0; hostWrite = 1'b0;
      if (hostRdata[7]) busyCnt++;
      else break;
    end
    check(busyCnt == LAT + 1, "R3 busy length", busyCnt, LAT + 1);
    if (w && int'(a) < REGS) model[a] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int k = 0; k < REGS; k++) model[k] = 16'hA500 + 16'(k);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(hostRdata == 32'h0, "R1 reset word", hostRdata, 32'h0);
    check(hostReady == 1'b1, "R10 ready held", {31'b0, hostReady}, 32'h1);

    // R10: idle host read changes nothing
    hostValid = 1'b1; hostWrite = 1'b0; hostWdata = 32'hFFFF_FFFF;
    @(negedge clk);
    hostValid = 1'b0;
    check(hostRdata == 32'h0, "R10 idle read quiet", hostRdata, 32'h0);

    doCmd(1'b0, 8'h00, 16'h0000, 0, "R8 R5 default reg 0x00");
    doCmd(1'b0, 8'h30, 16'h0000, 0, "R8 R5 default reg 0x30");
    doCmd(1'b0, 8'h31, 16'h0000, 0, "R9 read above bank");
    doCmd(1'b1, 8'h09, 16'h1234, 0, "R6 write result word");
    doCmd(1'b0, 8'h09, 16'h0000, 0, "R4 read back 0x09");
    doCmd(1'b1, 8'h31, 16'hBEEF, 0, "R6 write out of range");
    doCmd(1'b0, 8'h31, 16'h0000, 0, "R9 out-of-range write dropped");
    doCmd(1'b0, 8'h11, 16'h0000, 0, "R9 no alias into 0x11");
    doCmd(1'b1, 8'h20, 16'hCAFE, 1, "R7 busy command ignored");
    doCmd(1'b0, 8'h21, 16'h0000, 0, "R7 reg 0x21 untouched");
    doCmd(1'b0, 8'h20, 16'h0000, 2, "R4 R10 read 0x20 with host read");
    doCmd(1'b0, 8'hFF, 16'h0000, 0, "R9 read 0xFF");
    doCmd(1'b1, 8'h30, 16'hFFFF, 0, "R6 write top reg");
    doCmd(1'b0, 8'h30, 16'h0000, 1, "R4 R7 read top reg");

    // R6: data field holds after a write until next command
    doCmd(1'b1, 8'h05, 16'h0F0F, 0, "R6 write 0x05");
    repeat (5) @(negedge clk);
    check(hostRdata == 32'h0F0F_0501, "R6 data held", hostRdata, 32'h0F0F_0501);

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R3 all completions seen", expQ.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule